// File: doc/BRIEF.md
# NAND Page Layout Reordering Engine

This block stands between the byte stream a NAND controller moves over the flash bus and a byte-addressed page buffer on the user side. Over the bus a page travels in the controller's interleaved order. In the buffer the same page is always grouped: every data byte first, then every free spare byte, then every ECC byte. For each bus byte the engine works out where that byte belongs in the buffer. On a read it stores the incoming byte there. On a write it fetches the byte from there and drives it onto the bus.

Two layouts are supported. In the Hamming layout the page holds zero, one or two 512-byte chunks. On the bus the chunk data comes first, then one 6-byte digest per chunk, then the rest of the spare area. In the BCH layout the bus carries N identical sections, each made of data, free spare and a 32-byte ECC slot. Only 30 bytes of that slot carry ECC; the other two are 0xFF filler. An optional final section with its own data and spare sizes may follow, so that odd page geometries still add up. All sizes come from configuration inputs, which are captured when a walk starts. The bus side may pause at any byte, so a long page can be moved as several bursts without losing its place in the layout.

Top module: `nand_layout_remap`

## Requirements
- R1: After reset `busy`, `done`, `buf_we` and `buf_re` are all 0, and no buffer strobe is raised while the engine is idle.
- R2: Hamming read (`mode_bch`=0, `dir_write`=0) with C chunks of 512 bytes and spare size S: bus byte k < 512·C goes to buffer address k. The next 6·C bus bytes (the digests) go to 512·C + (S − 6·C) onwards. The last S − 6·C bus bytes go to 512·C onwards.
- R3: Hamming with C = 0 moves only the spare area, and bus byte k goes to buffer address k.
- R4: BCH read (`mode_bch`=1): within each section the data bytes fill the data region in order, the spare bytes fill the spare region (which starts at the page size), and 30 ECC bytes fill the ECC region (which starts at page size plus total free spare). The two trailing filler bytes of each section cause no buffer write.
- R5: Write direction (`dir_write`=1) walks the same layout. `bus_wdata` equals the buffer byte at the mapped address, and it is 0xFF on the two filler bytes of each BCH section.
- R6: With `cfg_last_en`=1, one extra BCH section follows the N regular ones, using `cfg_last_data` and `cfg_last_spare` as its sizes.
- R7: A BCH section whose spare size is 0 passes straight from its data field to its ECC field, and no bus byte is lost.
- R8: A cycle with `bus_step`=0 leaves the position in the layout unchanged, so inserting pauses between bytes yields the same buffer contents.
- R9: `cfg_err` is 1 in any of these cases: the Hamming chunk count exceeds 2; the section sizes do not sum to `cfg_page_bytes` and `cfg_spare_bytes`; the BCH section data size lies outside 512..2048; the section count is 0; the last section is enabled with a data size of 0 or above 2048; or page plus spare exceeds the buffer. A `start` while `cfg_err` is 1 does not begin a walk.
- R10: `done` is high for exactly one cycle, namely the cycle after the final bus byte is accepted, and `busy` is 0 in that same cycle.
- R11: A `start` or a change to the configuration while `busy` is 1 leaves the ongoing walk unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a page walk with the present configuration |
| dir_write | input | 1 | 0 = bus to buffer (read), 1 = buffer to bus (write) |
| mode_bch | input | 1 | 0 = Hamming layout, 1 = BCH layout |
| cfg_hm_chunks | input | 2 | Hamming 512-byte chunk count (0..2) |
| cfg_sec_count | input | CNT_W | Number of regular BCH sections |
| cfg_sec_data | input | SEC_W | Data bytes per regular BCH section |
| cfg_sec_spare | input | SPR_W | Free spare bytes per regular BCH section |
| cfg_last_en | input | 1 | Extra final BCH section present |
| cfg_last_data | input | SEC_W | Data bytes of the final section |
| cfg_last_spare | input | SPR_W | Free spare bytes of the final section |
| cfg_page_bytes | input | ADDR_W | Page data size in bytes |
| cfg_spare_bytes | input | ADDR_W | Spare area size in bytes |
| cfg_err | output | 1 | Configuration inconsistent |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at end of walk |
| bus_step | input | 1 | One bus byte moves this cycle |
| bus_rdata | input | 8 | Byte from the flash bus (read) |
| bus_wdata | output | 8 | Byte to the flash bus (write) |
| buf_addr | output | ADDR_W | Page buffer byte address |
| buf_we | output | 1 | Page buffer write strobe |
| buf_wdata | output | 8 | Page buffer write byte |
| buf_re | output | 1 | Page buffer read strobe |
| buf_rdata | input | 8 | Page buffer byte at buf_addr, same cycle |

## Verification
Every bus byte carries a value derived from its bus index, and every buffer byte carries a value derived from its address. Because of this, any byte that lands at the wrong place or is fetched from the wrong place shows up as a mismatch. The Hamming runs use two, one and zero chunks. They show whether the digests are placed after the free spare and whether an empty data field is skipped. The BCH runs cover three shapes: plain sections, a trailing odd section fed with pauses, and sections with no spare in write direction. Together they separate filler handling, the final-section sizes, the empty-field skip and position holding. Rejected configurations, and a restart attempt in the middle of a walk, check that the latched walk is protected.

// File: rtl/nlr_pkg.sv
package nlr_pkg;
  typedef enum logic [2:0] {
    ST_DATA  = 3'd0,
    ST_SPARE = 3'd1,
    ST_ECC   = 3'd2,
    ST_PAD   = 3'd3,
    ST_DONE  = 3'd4
  } walk_st_t;

  localparam int HM_CHUNK_BYTES = 512;
  localparam int HM_ECC_BYTES   = 6;
  localparam int BCH_ECC_BYTES  = 30;
  localparam int BCH_ECC_SLOT   = 32;
  localparam int BCH_SEC_MIN    = 512;
  localparam int BCH_SEC_MAX    = 2048;
endpackage

// File: rtl/nlr_cfg_check.sv
module nlr_cfg_check
  import nlr_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int SEC_W  = 12,
  parameter int SPR_W  = 8,
  parameter int CNT_W  = 4
) (
  input  logic              mode_bch,
  input  logic [1:0]        hm_chunks,
  input  logic [CNT_W-1:0]  sec_count,
  input  logic [SEC_W-1:0]  sec_data,
  input  logic [SPR_W-1:0]  sec_spare,
  input  logic              last_en,
  input  logic [SEC_W-1:0]  last_data,
  input  logic [SPR_W-1:0]  last_spare,
  input  logic [ADDR_W-1:0] page_bytes,
  input  logic [ADDR_W-1:0] spare_bytes,
  output logic              cfg_err,
  output logic [ADDR_W-1:0] free_total
);
  localparam int BASE_W = (SEC_W > ADDR_W) ? SEC_W : ADDR_W;
  localparam int WW     = BASE_W + CNT_W + 2;

  logic [WW-1:0] page_w, spare_w, limit_w;
  logic [WW-1:0] hm_data, hm_ecc, hm_free;
  logic [WW-1:0] bch_data, bch_spare, bch_free;
  logic          hm_bad, bch_bad, size_bad, last_bad, sec_bad;

  always_comb begin
    page_w    = WW'(page_bytes);
    spare_w   = WW'(spare_bytes);
    limit_w   = WW'(1) << ADDR_W;
    hm_data   = WW'(hm_chunks) * WW'(HM_CHUNK_BYTES);
    hm_ecc    = WW'(hm_chunks) * WW'(HM_ECC_BYTES);
    hm_free   = spare_w - hm_ecc;
    bch_data  = WW'(sec_count) * WW'(sec_data)
              + (last_en ? WW'(last_data) : '0);
    bch_spare = WW'(sec_count) * (WW'(sec_spare) + WW'(BCH_ECC_SLOT))
              + (last_en ? (WW'(last_spare) + WW'(BCH_ECC_SLOT)) : '0);
    bch_free  = WW'(sec_count) * WW'(sec_spare)
              + (last_en ? WW'(last_spare) : '0);

    sec_bad   = (WW'(sec_data) < WW'(BCH_SEC_MIN)) ||
                (WW'(sec_data) > WW'(BCH_SEC_MAX));
    last_bad  = last_en && ((last_data == '0) ||
                (WW'(last_data) > WW'(BCH_SEC_MAX)));
    hm_bad    = (hm_chunks > 2'd2) || (page_w != hm_data) ||
                (spare_w < hm_ecc);
    bch_bad   = (sec_count == '0) || sec_bad || last_bad ||
                (page_w != bch_data) || (spare_w != bch_spare);
    size_bad  = (page_w + spare_w) > limit_w;

    cfg_err    = size_bad || (mode_bch ? bch_bad : hm_bad);
    free_total = mode_bch ? bch_free[ADDR_W-1:0] : hm_free[ADDR_W-1:0];
  end
endmodule

// File: rtl/nlr_walker.sv
module nlr_walker
  import nlr_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int SEC_W  = 12,
  parameter int SPR_W  = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_go,
  input  logic              bus_step,
  input  logic              dir_write,
  input  logic              mode_bch,
  input  logic [1:0]        hm_chunks,
  input  logic [CNT_W-1:0]  sec_count,
  input  logic [SEC_W-1:0]  sec_data,
  input  logic [SPR_W-1:0]  sec_spare,
  input  logic              last_en,
  input  logic [SEC_W-1:0]  last_data,
  input  logic [SPR_W-1:0]  last_spare,
  input  logic [ADDR_W-1:0] page_bytes,
  input  logic [ADDR_W-1:0] free_in,
  output walk_st_t          st,
  output logic [ADDR_W-1:0] dptr,
  output logic [ADDR_W-1:0] sptr,
  output logic [ADDR_W-1:0] eptr,
  output logic [ADDR_W-1:0] page_q,
  output logic [ADDR_W-1:0] free_q,
  output logic              dir_q,
  output logic              busy,
  output logic              done
);
  localparam logic [CNT_W:0]  SEC_ONE = (CNT_W+1)'(1);
  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);

  // latched configuration
  logic              mode_q, last_en_q;
  logic [1:0]        chunks_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SEC_W-1:0]  secd_q, lastd_q;
  logic [SPR_W-1:0]  secs_q, lasts_q;

  // walk state
  walk_st_t          st_q, st_d, nxt, entry;
  logic [ADDR_W-1:0] off_q, off_d, field_len;
  logic [CNT_W-1:0]  sec_q, sec_d;
  logic [ADDR_W-1:0] dptr_q, dptr_d, sptr_q, sptr_d, eptr_q, eptr_d;
  logic              done_q, done_d;
  logic              cur_last, more, field_end, adv, walk_en;
  logic [SEC_W-1:0]  cur_data;
  logic [SPR_W-1:0]  cur_spare;
  logic [CNT_W:0]    sec_p1;

  assign busy    = (st_q != ST_DONE);
  assign adv     = bus_step && busy;
  assign walk_en = start_go || adv;

  // field geometry and successor
  always_comb begin
    cur_last  = last_en_q && (sec_q == cnt_q);
    cur_data  = cur_last ? lastd_q : secd_q;
    cur_spare = cur_last ? lasts_q : secs_q;
    sec_p1    = {1'b0, sec_q} + SEC_ONE;
    more      = (sec_p1 < {1'b0, cnt_q}) ||
                (last_en_q && (sec_p1 == {1'b0, cnt_q}));
    field_len = A_ONE;
    nxt       = ST_DONE;
    case (st_q)
      ST_DATA: begin
        field_len = mode_q ? ADDR_W'(cur_data)
                           : ADDR_W'(chunks_q) * ADDR_W'(HM_CHUNK_BYTES);
        if (mode_q) nxt = (cur_spare == '0) ? ST_ECC : ST_SPARE;
        else        nxt = ST_ECC;
      end
      ST_SPARE: begin
        field_len = mode_q ? ADDR_W'(cur_spare) : free_q;
        nxt       = mode_q ? ST_ECC : ST_DONE;
      end
      ST_ECC: begin
        field_len = mode_q ? ADDR_W'(BCH_ECC_BYTES)
                           : ADDR_W'(chunks_q) * ADDR_W'(HM_ECC_BYTES);
        if (mode_q) nxt = ST_PAD;
        else        nxt = (free_q == '0) ? ST_DONE : ST_SPARE;
      end
      ST_PAD: begin
        field_len = ADDR_W'(BCH_ECC_SLOT - BCH_ECC_BYTES);
        nxt       = more ? ST_DATA : ST_DONE;
      end
      default: begin
        field_len = A_ONE;
        nxt       = ST_DONE;
      end
    endcase
    field_end = (off_q == field_len - A_ONE);

    if (mode_bch)              entry = ST_DATA;
    else if (hm_chunks != '0)  entry = ST_DATA;
    else if (free_in != '0)    entry = ST_SPARE;
    else                       entry = ST_DONE;
  end

  // next state
  always_comb begin
    st_d   = st_q;
    off_d  = off_q;
    sec_d  = sec_q;
    dptr_d = dptr_q;
    sptr_d = sptr_q;
    eptr_d = eptr_q;
    done_d = 1'b0;
    if (start_go) begin
      st_d   = entry;
      off_d  = '0;
      sec_d  = '0;
      dptr_d = '0;
      sptr_d = '0;
      eptr_d = '0;
      done_d = (entry == ST_DONE);
    end else if (adv) begin
      case (st_q)
        ST_DATA:  dptr_d = dptr_q + A_ONE;
        ST_SPARE: sptr_d = sptr_q + A_ONE;
        ST_ECC:   eptr_d = eptr_q + A_ONE;
        default:  ;
      endcase
      if (field_end) begin
        off_d  = '0;
        st_d   = nxt;
        done_d = (nxt == ST_DONE);
        if ((st_q == ST_PAD) && (nxt == ST_DATA)) sec_d = sec_p1[CNT_W-1:0];
      end else begin
        off_d = off_q + A_ONE;
      end
    end
  end

  // walk registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_DONE;
      off_q  <= '0;
      sec_q  <= '0;
      dptr_q <= '0;
      sptr_q <= '0;
      eptr_q <= '0;
    end else if (walk_en) begin
      st_q   <= st_d;
      off_q  <= off_d;
      sec_q  <= sec_d;
      dptr_q <= dptr_d;
      sptr_q <= sptr_d;
      eptr_q <= eptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  // configuration capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      dir_q     <= 1'b0;
      last_en_q <= 1'b0;
      chunks_q  <= '0;
      cnt_q     <= '0;
      secd_q    <= '0;
      secs_q    <= '0;
      lastd_q   <= '0;
      lasts_q   <= '0;
      page_q    <= '0;
      free_q    <= '0;
    end else if (start_go) begin
      mode_q    <= mode_bch;
      dir_q     <= dir_write;
      last_en_q <= last_en;
      chunks_q  <= hm_chunks;
      cnt_q     <= sec_count;
      secd_q    <= sec_data;
      secs_q    <= sec_spare;
      lastd_q   <= last_data;
      lasts_q   <= last_spare;
      page_q    <= page_bytes;
      free_q    <= free_in;
    end
  end

  assign st   = st_q;
  assign dptr = dptr_q;
  assign sptr = sptr_q;
  assign eptr = eptr_q;
  assign done = done_q;
endmodule

// File: rtl/nlr_addr_gen.sv
module nlr_addr_gen
  import nlr_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  walk_st_t          st,
  input  logic [ADDR_W-1:0] dptr,
  input  logic [ADDR_W-1:0] sptr,
  input  logic [ADDR_W-1:0] eptr,
  input  logic [ADDR_W-1:0] page_q,
  input  logic [ADDR_W-1:0] free_q,
  input  logic              dir_q,
  input  logic              bus_step,
  input  logic [7:0]        bus_rdata,
  input  logic [7:0]        buf_rdata,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              buf_we,
  output logic              buf_re,
  output logic [7:0]        buf_wdata,
  output logic [7:0]        bus_wdata
);
  logic user_field;

  always_comb begin
    user_field = (st == ST_DATA) || (st == ST_SPARE) || (st == ST_ECC);
    case (st)
      ST_DATA:  buf_addr = dptr;
      ST_SPARE: buf_addr = page_q + sptr;
      ST_ECC:   buf_addr = page_q + free_q + eptr;
      default:  buf_addr = '0;
    endcase
    buf_we    = bus_step && user_field && !dir_q;
    buf_re    = bus_step && user_field && dir_q;
    buf_wdata = bus_rdata;
    if (!dir_q)           bus_wdata = 8'h00;
    else if (st == ST_PAD) bus_wdata = 8'hFF;
    else                   bus_wdata = buf_rdata;
  end
endmodule

// File: rtl/nand_layout_remap.sv
module nand_layout_remap
  import nlr_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int SEC_W  = 12,
  parameter int SPR_W  = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_write,
  input  logic              mode_bch,
  input  logic [1:0]        cfg_hm_chunks,
  input  logic [CNT_W-1:0]  cfg_sec_count,
  input  logic [SEC_W-1:0]  cfg_sec_data,
  input  logic [SPR_W-1:0]  cfg_sec_spare,
  input  logic              cfg_last_en,
  input  logic [SEC_W-1:0]  cfg_last_data,
  input  logic [SPR_W-1:0]  cfg_last_spare,
  input  logic [ADDR_W-1:0] cfg_page_bytes,
  input  logic [ADDR_W-1:0] cfg_spare_bytes,
  output logic              cfg_err,
  output logic              busy,
  output logic              done,
  input  logic              bus_step,
  input  logic [7:0]        bus_rdata,
  output logic [7:0]        bus_wdata,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              buf_we,
  output logic [7:0]        buf_wdata,
  output logic              buf_re,
  input  logic [7:0]        buf_rdata
);
  logic              rst_meta, rst_n_int;
  logic              start_go, dir_lat;
  logic [ADDR_W-1:0] free_total, dptr, sptr, eptr, page_q, free_q;
  walk_st_t          walk_st;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_n_int <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_n_int <= rst_meta;
    end
  end

  assign start_go = start && !cfg_err && !busy;

  nlr_cfg_check #(
    .ADDR_W(ADDR_W), .SEC_W(SEC_W), .SPR_W(SPR_W), .CNT_W(CNT_W)
  ) u_cfg (
    .mode_bch    (mode_bch),
    .hm_chunks   (cfg_hm_chunks),
    .sec_count   (cfg_sec_count),
    .sec_data    (cfg_sec_data),
    .sec_spare   (cfg_sec_spare),
    .last_en     (cfg_last_en),
    .last_data   (cfg_last_data),
    .last_spare  (cfg_last_spare),
    .page_bytes  (cfg_page_bytes),
    .spare_bytes (cfg_spare_bytes),
    .cfg_err     (cfg_err),
    .free_total  (free_total)
  );

  nlr_walker #(
    .ADDR_W(ADDR_W), .SEC_W(SEC_W), .SPR_W(SPR_W), .CNT_W(CNT_W)
  ) u_walk (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start_go   (start_go),
    .bus_step   (bus_step),
    .dir_write  (dir_write),
    .mode_bch   (mode_bch),
    .hm_chunks  (cfg_hm_chunks),
    .sec_count  (cfg_sec_count),
    .sec_data   (cfg_sec_data),
    .sec_spare  (cfg_sec_spare),
    .last_en    (cfg_last_en),
    .last_data  (cfg_last_data),
    .last_spare (cfg_last_spare),
    .page_bytes (cfg_page_bytes),
    .free_in    (free_total),
    .st         (walk_st),
    .dptr       (dptr),
    .sptr       (sptr),
    .eptr       (eptr),
    .page_q     (page_q),
    .free_q     (free_q),
    .dir_q      (dir_lat),
    .busy       (busy),
    .done       (done)
  );

  nlr_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .st        (walk_st),
    .dptr      (dptr),
    .sptr      (sptr),
    .eptr      (eptr),
    .page_q    (page_q),
    .free_q    (free_q),
    .dir_q     (dir_lat),
    .bus_step  (bus_step),
    .bus_rdata (bus_rdata),
    .buf_rdata (buf_rdata),
    .buf_addr  (buf_addr),
    .buf_we    (buf_we),
    .buf_re    (buf_re),
    .buf_wdata (buf_wdata),
    .bus_wdata (bus_wdata)
  );
endmodule

// File: rtl/nand_layout_remap_chk.sv
module nand_layout_remap_chk
  import nlr_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              cfg_err,
  input logic              bus_step,
  input logic              busy,
  input logic              done,
  input logic              buf_we,
  input logic              buf_re,
  input logic [ADDR_W-1:0] buf_addr,
  input logic [7:0]        bus_wdata,
  input walk_st_t          walk_st,
  input logic              dir_lat
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!buf_we && !buf_re));

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_we && buf_re));

  assert_pad_no_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_st == ST_PAD) |-> (!buf_we && !buf_re));

  assert_pad_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_st == ST_PAD && dir_lat) |-> (bus_wdata == 8'hFF));

  assert_hold_pos_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_step) |=> ($stable(walk_st) && $stable(buf_addr)));

  assert_err_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && cfg_err) |=> !busy);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind nand_layout_remap nand_layout_remap_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_int),
  .start     (start),
  .cfg_err   (cfg_err),
  .bus_step  (bus_step),
  .busy      (busy),
  .done      (done),
  .buf_we    (buf_we),
  .buf_re    (buf_re),
  .buf_addr  (buf_addr),
  .bus_wdata (bus_wdata),
  .walk_st   (walk_st),
  .dir_lat   (dir_lat)
);

// File: tb/test_nand_layout_remap.sv
`timescale 1ns/1ps
module test_nand_layout_remap;
  localparam int ADDR_W = 14;
  localparam int SEC_W  = 12;
  localparam int SPR_W  = 8;
  localparam int CNT_W  = 4;
  localparam int MEM    = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start, dir_write, mode_bch, cfg_last_en;
  logic [1:0]        cfg_hm_chunks;
  logic [CNT_W-1:0]  cfg_sec_count;
  logic [SEC_W-1:0]  cfg_sec_data, cfg_last_data;
  logic [SPR_W-1:0]  cfg_sec_spare, cfg_last_spare;
  logic [ADDR_W-1:0] cfg_page_bytes, cfg_spare_bytes;
  logic              cfg_err, busy, done;
  logic              bus_step;
  logic [7:0]        bus_rdata, bus_wdata;
  logic [ADDR_W-1:0] buf_addr;
  logic              buf_we, buf_re;
  logic [7:0]        buf_wdata, buf_rdata;

  int total = 0;
  int bad   = 0;
  logic [7:0] ubuf [0:MEM-1];
  logic [7:0] cap  [0:MEM-1];
  int         map_a[0:MEM-1];
  int         nbus, npad, we_cnt, re_cnt;
  logic       done_seen, busy_after;

  always #4 clk = ~clk;

  nand_layout_remap #(
    .ADDR_W(ADDR_W), .SEC_W(SEC_W), .SPR_W(SPR_W), .CNT_W(CNT_W)
  ) i_nand_layout_remap (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_write(dir_write),
    .mode_bch(mode_bch), .cfg_hm_chunks(cfg_hm_chunks),
    .cfg_sec_count(cfg_sec_count), .cfg_sec_data(cfg_sec_data),
    .cfg_sec_spare(cfg_sec_spare), .cfg_last_en(cfg_last_en),
    .cfg_last_data(cfg_last_data), .cfg_last_spare(cfg_last_spare),
    .cfg_page_bytes(cfg_page_bytes), .cfg_spare_bytes(cfg_spare_bytes),
    .cfg_err(cfg_err), .busy(busy), .done(done),
    .bus_step(bus_step), .bus_rdata(bus_rdata), .bus_wdata(bus_wdata),
    .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .buf_re(buf_re), .buf_rdata(buf_rdata)
  );

  assign buf_rdata = ubuf[buf_addr];
  always @(posedge clk) if (buf_we) ubuf[buf_addr] <= buf_wdata;

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bus_val(input int k);
    return 8'((k * 7 + 3) ^ (k >> 8));
  endfunction

  function automatic logic [7:0] usr_val(input int a);
    return 8'(a * 13 + 5);
  endfunction

  task automatic clear_cfg();
    mode_bch = 0; cfg_hm_chunks = '0; cfg_sec_count = '0; cfg_sec_data = '0;
    cfg_sec_spare = '0; cfg_last_en = 0; cfg_last_data = '0; cfg_last_spare = '0;
    cfg_page_bytes = '0; cfg_spare_bytes = '0;
  endtask

  // expected Hamming walk
  task automatic set_hm(input int ch, input int sp);
    int d, fr, idx;
    clear_cfg();
    cfg_hm_chunks = 2'(ch);
    d = ch * 512; fr = sp - 6 * ch; idx = 0;
    cfg_page_bytes = ADDR_W'(d); cfg_spare_bytes = ADDR_W'(sp);
    for (int k = 0; k < d; k++)      begin map_a[idx] = k; idx++; end
    for (int j = 0; j < 6 * ch; j++) begin map_a[idx] = d + fr + j; idx++; end
    for (int j = 0; j < fr; j++)     begin map_a[idx] = d + j; idx++; end
    nbus = idx; npad = 0;
  endtask

  // expected BCH walk
  task automatic set_bch(input int n, input int sd, input int ss,
                         input int le, input int ld, input int ls);
    int d, fr, sp, idx, dp, fp, ep, nsec, len_d, len_s;
    clear_cfg();
    mode_bch = 1;
    cfg_sec_count = CNT_W'(n); cfg_sec_data = SEC_W'(sd); cfg_sec_spare = SPR_W'(ss);
    cfg_last_en = le[0]; cfg_last_data = SEC_W'(ld); cfg_last_spare = SPR_W'(ls);
    d  = n * sd + (le != 0 ? ld : 0);
    fr = n * ss + (le != 0 ? ls : 0);
    sp = n * (ss + 32) + (le != 0 ? ls + 32 : 0);
    cfg_page_bytes = ADDR_W'(d); cfg_spare_bytes = ADDR_W'(sp);
    nsec = n + (le != 0 ? 1 : 0);
    idx = 0; dp = 0; fp = 0; ep = 0;
    for (int s = 0; s < nsec; s++) begin
      len_d = (s == n) ? ld : sd;
      len_s = (s == n) ? ls : ss;
      for (int j = 0; j < len_d; j++) begin map_a[idx] = dp; dp++; idx++; end
      for (int j = 0; j < len_s; j++) begin map_a[idx] = d + fp; fp++; idx++; end
      for (int j = 0; j < 30; j++)    begin map_a[idx] = d + fr + ep; ep++; idx++; end
      for (int j = 0; j < 2; j++)     begin map_a[idx] = -1; idx++; end
    end
    nbus = idx; npad = 2 * nsec;
  endtask

  task automatic fill_buf(input bit pattern);
    for (int a = 0; a < MEM; a++) ubuf[a] = pattern ? usr_val(a) : 8'hEE;
  endtask

  task automatic start_walk(input bit wr);
    @(negedge clk);
    dir_write = wr; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  // drive nbus bytes; pause 3 cycles every gap bytes; try a restart at disturb
  task automatic run(input int gap, input int disturb);
    we_cnt = 0; re_cnt = 0;
    for (int k = 0; k < nbus; k++) begin
      @(negedge clk);
      if (gap > 0 && k > 0 && (k % gap) == 0) begin
        bus_step = 0;
        repeat (3) @(negedge clk);
      end
      if (k == disturb) begin
        start = 1; mode_bch = ~mode_bch; cfg_page_bytes = '0; dir_write = ~dir_write;
      end else begin
        start = 0;
      end
      bus_step = 1; bus_rdata = bus_val(k);
      #1;
      cap[k] = bus_wdata;
      if (buf_we) we_cnt++;
      if (buf_re) re_cnt++;
    end
    @(negedge clk);
    bus_step = 0; start = 0;
    #1;
    done_seen = done; busy_after = busy;
  endtask

  function automatic int read_errs();
    int e = 0;
    for (int k = 0; k < nbus; k++)
      if (map_a[k] >= 0 && ubuf[map_a[k]] !== bus_val(k)) e++;
    return e;
  endfunction

  function automatic int write_errs();
    int e = 0;
    for (int k = 0; k < nbus; k++) begin
      if (map_a[k] < 0) begin
        if (cap[k] !== 8'hFF) e++;
      end else if (cap[k] !== usr_val(map_a[k])) e++;
    end
    return e;
  endfunction

  task automatic t_reset();
    #1;
    check("R1", "busy after reset", int'(busy), 0);
    check("R1", "done after reset", int'(done), 0);
    check("R1", "buffer strobes idle", int'(buf_we | buf_re), 0);
  endtask

  task automatic t_hm_read_two();
    set_hm(2, 32);
    fill_buf(0);
    #1 check("R9", "good hamming cfg", int'(cfg_err), 0);
    start_walk(0);
    run(0, -1);
    check("R2", "hamming 2-chunk byte placement", read_errs(), 0);
    check("R2", "hamming writes", we_cnt, nbus);
    check("R10", "done after last byte", int'(done_seen), 1);
    check("R10", "busy with done", int'(busy_after), 0);
    @(negedge clk); #1;
    check("R10", "done one cycle", int'(done), 0);
  endtask

  task automatic t_hm_zero();
    set_hm(0, 16);
    fill_buf(0);
    start_walk(0);
    run(0, -1);
    check("R3", "zero-chunk spare placement", read_errs(), 0);
    check("R3", "zero-chunk writes", we_cnt, 16);
  endtask

  task automatic t_hm_write_one();
    set_hm(1, 24);
    fill_buf(1);
    start_walk(1);
    run(0, -1);
    check("R5", "hamming write bus bytes", write_errs(), 0);
    check("R5", "hamming buffer reads", re_cnt, nbus);
  endtask

  task automatic t_bch_read();
    set_bch(2, 512, 8, 0, 0, 0);
    fill_buf(0);
    #1 check("R9", "good bch cfg", int'(cfg_err), 0);
    start_walk(0);
    run(0, -1);
    check("R4", "bch byte placement", read_errs(), 0);
    check("R4", "filler bytes not stored", we_cnt, nbus - npad);
  endtask

  task automatic t_bch_last_gaps();
    set_bch(2, 512, 6, 1, 300, 10);
    fill_buf(0);
    start_walk(0);
    run(37, -1);
    check("R6", "last-section placement", read_errs(), 0);
    check("R8", "paused walk writes", we_cnt, nbus - npad);
    check("R8", "paused walk done", int'(done_seen), 1);
  endtask

  task automatic t_bch_write_nospare();
    set_bch(1, 1024, 0, 1, 512, 4);
    fill_buf(1);
    start_walk(1);
    run(0, -1);
    check("R7", "zero-spare section write stream", write_errs(), 0);
    check("R5", "filler reads skipped", re_cnt, nbus - npad);
  endtask

  task automatic t_cfg_err();
    set_bch(2, 512, 8, 0, 0, 0);
    cfg_spare_bytes = cfg_spare_bytes + ADDR_W'(1);
    #1 check("R9", "spare sum mismatch", int'(cfg_err), 1);
    start_walk(0);
    #1 check("R9", "start ignored on error", int'(busy), 0);
    set_bch(2, 256, 8, 0, 0, 0);
    #1 check("R9", "section data too small", int'(cfg_err), 1);
    set_hm(2, 32);
    cfg_hm_chunks = 2'd3; cfg_page_bytes = ADDR_W'(1536);
    #1 check("R9", "too many chunks", int'(cfg_err), 1);
    set_hm(2, 32);
    cfg_page_bytes = ADDR_W'(1000);
    #1 check("R9", "page size mismatch", int'(cfg_err), 1);
  endtask

  task automatic t_busy_start();
    set_bch(1, 512, 4, 0, 0, 0);
    fill_buf(0);
    start_walk(0);
    run(0, 100);
    check("R11", "restart while busy ignored", read_errs(), 0);
    check("R11", "walk length kept", int'(done_seen), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; start = 0; dir_write = 0; bus_step = 0; bus_rdata = '0;
    clear_cfg();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_hm_read_two();
    t_hm_zero();
    t_hm_write_one();
    t_bch_read();
    t_bch_last_gaps();
    t_bch_write_nospare();
    t_cfg_err();
    t_busy_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule